// File: doc/BRIEF.md
# Conversion Flag Clear Controller

This block keeps one conversion-complete flag per channel of a sequenced converter. A flag rises when the converter stores a result for its channel. Software can then clear the flag in one of two ways, selected by a control bit. In the default way, software writes a one to the flag's position in the flag register. In the fast way, the clear comes as a side effect of touching the channel's result register. With compare off for that channel, a read of the result clears the flag. With compare on, a write to the result clears it.

On a channel with compare enabled, the flag rises only when the compare succeeded, so a set flag means a match. The block also keeps a sequence-complete flag. It drives two interrupt lines: one for sequence completion and one for compare hits. Any write to the control register produces a one-cycle abort pulse, which tells the converter to drop the sequence it is running.

Top module: `cflag_ctrl`

## Requirements
- R1: After reset, every channel flag, the sequence-complete flag, both interrupt enables, both interrupt lines and the abort pulse are 0, and the clear mode is write-one-to-clear.
- R2: A `res_valid[n]` strobe sets `flags[n]` on the next cycle when `cmp_en[n]`=0. When `cmp_en[n]`=1 it sets the flag only if `cmp_match[n]` is also 1.
- R3: With control bit 0 = 0, a `flag_wr` clears each flag whose `flag_wdata` bit is 1 and leaves the flags whose bit is 0 unchanged. In this mode, result reads and writes have no effect on any flag.
- R4: With control bit 0 = 1 and `cmp_en[n]`=0, a `res_rd` with `res_idx`=n clears `flags[n]`. A `res_wr` to n leaves it set.
- R5: With control bit 0 = 1 and `cmp_en[n]`=1, a `res_wr` with `res_idx`=n clears `flags[n]`. A `res_rd` of n leaves it set.
- R6: With control bit 0 = 1, `flag_wr` has no effect on any flag.
- R7: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R8: `seq_done` sets `seq_flag` on the next cycle. `seq_clr` clears it. If both arrive together, the set wins.
- R9: `seq_irq` is high exactly when control bit 1 is 1 and `seq_flag` is 1.
- R10: `cmp_irq` is high exactly when control bit 2 is 1 and some channel n has both `flags[n]` and `cmp_en[n]` at 1.
- R11: A `ctl_wr` drives `abort` high for exactly the next cycle. The new control value takes effect from that cycle on. Flag updates in the cycle of the write still use the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | N_CH | Per-channel result-stored strobe |
| cmp_en | input | N_CH | Per-channel compare enable |
| cmp_match | input | N_CH | Per-channel compare success |
| res_rd | input | 1 | Result register read strobe |
| res_wr | input | 1 | Result register write strobe |
| res_idx | input | IDX_W | Channel index of the result access |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | N_CH | Flag register write data, ones clear |
| seq_done | input | 1 | Sequence-complete strobe |
| seq_clr | input | 1 | Write-one clear of the sequence flag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Bit 0 fast clear, bit 1 sequence irq enable, bit 2 compare irq enable |
| flags | output | N_CH | Conversion-complete flags |
| seq_flag | output | 1 | Sequence-complete flag |
| seq_irq | output | 1 | Sequence-complete interrupt |
| cmp_irq | output | 1 | Compare interrupt |
| abort | output | 1 | One-cycle sequence abort pulse |

## Verification
The bench builds the block with four channels and a two-bit index. This makes it feasible to sweep every channel, both compare settings and every kind of access in both clear modes. A small arithmetic model, kept next to that sweep, predicts every flag after each cycle. A long pseudo-random phase then drives every input, control writes included. That phase reaches collisions, mode switches in mid-stream and interrupt combinations that the directed sweep does not line up by hand.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
   typedef enum logic {
      CLR_W1C    = 1'b0,
      CLR_ACCESS = 1'b1
   } clr_mode_e;

   typedef struct packed {
      logic      cmp_ie;
      logic      seq_ie;
      clr_mode_e mode;
   } ctl_t;

   localparam int CTL_W = 3;
endpackage

// File: rtl/cflag_ctl.sv
module cflag_ctl
   import cflag_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output ctl_t             ctl,
   output logic             abort
);
   ctl_t ctl_q;
   logic abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '{cmp_ie: 1'b0, seq_ie: 1'b0, mode: CLR_W1C};
         abort_q <= 1'b0;
      end else begin
         abort_q <= wr;
         if (wr) ctl_q <= ctl_t'(wdata);
      end
   end

   assign ctl   = ctl_q;
   assign abort = abort_q;
endmodule

// File: rtl/cflag_cell.sv
module cflag_cell
   import cflag_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  clr_mode_e mode,
   input  logic      valid,
   input  logic      cmp_on,
   input  logic      match,
   input  logic      rd_hit,
   input  logic      wr_hit,
   input  logic      w1c,
   output logic      flag
);
   logic set_ev, clr_ev, flag_q;

   always_comb begin
      set_ev = valid && (!cmp_on || match);
      unique case (mode)
         CLR_ACCESS: clr_ev = cmp_on ? wr_hit : rd_hit;
         default:    clr_ev = w1c;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/cflag_seq.sv
module cflag_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (done) flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/cflag_ctrl.sv
module cflag_ctrl
   import cflag_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  res_valid,
   input  logic [N_CH-1:0]  cmp_en,
   input  logic [N_CH-1:0]  cmp_match,
   input  logic             res_rd,
   input  logic             res_wr,
   input  logic [IDX_W-1:0] res_idx,
   input  logic             flag_wr,
   input  logic [N_CH-1:0]  flag_wdata,
   input  logic             seq_done,
   input  logic             seq_clr,
   input  logic             ctl_wr,
   input  logic [2:0]       ctl_wdata,
   output logic [N_CH-1:0]  flags,
   output logic             seq_flag,
   output logic             seq_irq,
   output logic             cmp_irq,
   output logic             abort
);
   localparam int MIN_IDX = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 1 || N_CH > 64) begin : g_bad_ch
      $error("cflag_ctrl: N_CH out of range");
   end
   if (IDX_W < MIN_IDX) begin : g_bad_idx
      $error("cflag_ctrl: IDX_W too narrow for N_CH");
   end

   ctl_t      ctl;
   clr_mode_e fast_mode;

   cflag_ctl u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wdata (ctl_wdata),
      .ctl   (ctl),
      .abort (abort)
   );

   assign fast_mode = ctl.mode;

   for (genvar n = 0; n < N_CH; n++) begin : g_ch
      localparam logic [IDX_W-1:0] CH = IDX_W'(n);
      logic hit;
      assign hit = (res_idx == CH);

      cflag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .mode   (fast_mode),
         .valid  (res_valid[n]),
         .cmp_on (cmp_en[n]),
         .match  (cmp_match[n]),
         .rd_hit (res_rd && hit),
         .wr_hit (res_wr && hit),
         .w1c    (flag_wr && flag_wdata[n]),
         .flag   (flags[n])
      );
   end

   cflag_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (seq_done),
      .clr   (seq_clr),
      .flag  (seq_flag)
   );

   assign seq_irq = ctl.seq_ie && seq_flag;
   assign cmp_irq = ctl.cmp_ie && |(flags & cmp_en);
endmodule

// File: rtl/cflag_chk.sv
module cflag_chk
   import cflag_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_CH-1:0]  res_valid,
   input logic [N_CH-1:0]  cmp_en,
   input logic [N_CH-1:0]  cmp_match,
   input logic             res_rd,
   input logic             res_wr,
   input logic [IDX_W-1:0] res_idx,
   input logic             flag_wr,
   input logic [N_CH-1:0]  flag_wdata,
   input logic             seq_done,
   input logic             ctl_wr,
   input logic [N_CH-1:0]  flags,
   input logic             seq_flag,
   input logic             seq_irq,
   input logic             cmp_irq,
   input logic             abort,
   input clr_mode_e        fast_mode
);
   for (genvar n = 0; n < N_CH; n++) begin : g_a
      localparam logic [IDX_W-1:0] CH = IDX_W'(n);

      assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid[n] && (!cmp_en[n] || cmp_match[n]) |=> flags[n]);

      assert_w1c_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
         fast_mode == CLR_W1C && flags[n] && !(flag_wr && flag_wdata[n]) |=> flags[n]);

      assert_rd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         fast_mode == CLR_ACCESS && !cmp_en[n] && res_rd && res_idx == CH && !res_valid[n]
         |=> !flags[n]);

      assert_wr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         fast_mode == CLR_ACCESS && cmp_en[n] && res_wr && res_idx == CH && !res_valid[n]
         |=> !flags[n]);
   end

   assert_seq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> seq_flag);

   assert_seq_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_irq |-> seq_flag);

   assert_cmp_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_irq |-> |(flags & cmp_en));

   assert_abort_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> abort);

   assert_abort_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> $past(ctl_wr));
endmodule

bind cflag_ctrl cflag_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_cflag_ctrl.sv
`timescale 1ns/1ps
module sim_cflag_ctrl;
   localparam int N = 4;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]  res_valid = '0, cmp_en = '0, cmp_match = '0, flag_wdata = '0;
   logic          res_rd = 0, res_wr = 0, flag_wr = 0, seq_done = 0, seq_clr = 0, ctl_wr = 0;
   logic [IW-1:0] res_idx = '0;
   logic [2:0]    ctl_wdata = '0;
   logic [N-1:0]  flags;
   logic          seq_flag, seq_irq, cmp_irq, abort;

   int checks = 0, errors = 0;
   logic [N-1:0] m_flags = '0;
   logic m_seq = 0, m_fast = 0, m_sie = 0, m_cie = 0;

   always #2 clk = ~clk;

   cflag_ctrl #(.N_CH(N), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .cmp_en(cmp_en),
      .cmp_match(cmp_match), .res_rd(res_rd), .res_wr(res_wr), .res_idx(res_idx),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .seq_done(seq_done),
      .seq_clr(seq_clr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .flags(flags),
      .seq_flag(seq_flag), .seq_irq(seq_irq), .cmp_irq(cmp_irq), .abort(abort)
   );

   task automatic chk(input logic ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic e_sirq, e_cirq;
      e_sirq = m_sie && m_seq;
      e_cirq = m_cie && |(m_flags & cmp_en);
      chk(flags == m_flags, tag, "flags", int'(flags), int'(m_flags));
      chk(seq_flag == m_seq, tag, "seq_flag", int'(seq_flag), int'(m_seq));
      chk(seq_irq == e_sirq, tag, "seq_irq", int'(seq_irq), int'(e_sirq));
      chk(cmp_irq == e_cirq, tag, "cmp_irq", int'(cmp_irq), int'(e_cirq));
   endtask

   // Called at a falling edge; holds inputs for one rising edge, checks at the next falling edge.
   task automatic cyc(input logic [N-1:0] rv, input logic [N-1:0] ce, input logic [N-1:0] cm,
                      input logic rd, input logic wr, input logic [IW-1:0] idx,
                      input logic fw, input logic [N-1:0] fwd,
                      input logic sd, input logic sc, input logic cw, input logic [2:0] cwd,
                      input string tag);
      logic [N-1:0] nf;
      res_valid = rv; cmp_en = ce; cmp_match = cm; res_rd = rd; res_wr = wr;
      res_idx = idx; flag_wr = fw; flag_wdata = fwd; seq_done = sd; seq_clr = sc;
      ctl_wr = cw; ctl_wdata = cwd;
      for (int n = 0; n < N; n++) begin
         logic s, c;
         s = rv[n] && (!ce[n] || cm[n]);
         if (m_fast) c = (idx == IW'(n)) && (ce[n] ? wr : rd);
         else        c = fw && fwd[n];
         nf[n] = s | (m_flags[n] & ~c);
      end
      m_flags = nf;
      m_seq = sd | (m_seq & ~sc);
      if (cw) begin m_fast = cwd[0]; m_sie = cwd[1]; m_cie = cwd[2]; end
      @(negedge clk);
      compare(tag);
      chk(abort == cw, tag, "abort", int'(abort), int'(cw));
   endtask

   task automatic idle(input logic [N-1:0] ce, input string tag);
      cyc('0, ce, '0, 0, 0, '0, 0, '0, 0, 0, 0, 3'b0, tag);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      compare("R1");
      chk(abort == 1'b0, "R1", "abort", int'(abort), 0);

      // Exhaustive sweep: mode x channel x compare setting x access kind
      for (int md = 0; md < 2; md++) begin
         cyc('0, '0, '0, 0, 0, '0, 0, '0, 0, 0, 1, {2'b11, md[0]}, "R11");
         idle('0, "R11");
         for (int ch = 0; ch < N; ch++) begin
            for (int cb = 0; cb < 2; cb++) begin
               for (int op = 0; op < 4; op++) begin
                  logic [N-1:0] bit_v, cev;
                  string t;
                  bit_v = N'(1) << ch;
                  cev = cb ? bit_v : '0;
                  cyc(bit_v, cev, bit_v, 0, 0, '0, 0, '0, 0, 0, 0, 3'b0, "R2");
                  if (md == 0) t = "R3";
                  else if (op >= 2) t = "R6";
                  else t = cb ? "R5" : "R4";
                  case (op)
                     0: cyc('0, cev, '0, 1, 0, IW'(ch), 0, '0, 0, 0, 0, 3'b0, t);
                     1: cyc('0, cev, '0, 0, 1, IW'(ch), 0, '0, 0, 0, 0, 3'b0, t);
                     2: cyc('0, cev, '0, 0, 0, '0, 1, bit_v, 0, 0, 0, 3'b0, t);
                     default: cyc('0, cev, '0, 0, 0, '0, 1, ~bit_v, 0, 0, 0, 3'b0, t);
                  endcase
                  // R10: drop compare enable on the channel and look at the line
                  idle('0, "R10");
               end
            end
         end
         // R7 collisions: set and clear on channel 1 together
         cyc(4'b0010, '0, '0, 1, 0, 2'd1, 1, 4'b0010, 0, 0, 0, 3'b0, "R7");
         cyc(4'b0010, 4'b0010, 4'b0010, 0, 1, 2'd1, 1, 4'b0010, 0, 0, 0, 3'b0, "R7");
         // R2: compare miss leaves flag 3 unchanged
         cyc('0, '0, '0, 0, 0, '0, 1, 4'b1000, 0, 0, 0, 3'b0, "R3");
         cyc(4'b1000, 4'b1000, '0, 1, 0, 2'd3, 0, '0, 0, 0, 0, 3'b0, "R2");
      end

      // R8 and R9: sequence flag with interrupt on and off
      cyc('0, '0, '0, 0, 0, '0, 0, '0, 1, 0, 0, 3'b0, "R8");
      cyc('0, '0, '0, 0, 0, '0, 0, '0, 0, 0, 1, 3'b010, "R9");
      idle('0, "R9");
      cyc('0, '0, '0, 0, 0, '0, 0, '0, 1, 1, 0, 3'b0, "R8");
      cyc('0, '0, '0, 0, 0, '0, 0, '0, 0, 1, 0, 3'b0, "R8");
      cyc('0, '0, '0, 0, 0, '0, 0, '0, 1, 0, 1, 3'b000, "R9");
      idle('0, "R9");

      // R10: compare interrupt follows enable and the compare-enable mask
      cyc('0, '0, '0, 0, 0, '0, 0, '0, 0, 0, 1, 3'b100, "R10");
      cyc(4'b0100, 4'b0100, 4'b0100, 0, 0, '0, 0, '0, 0, 0, 0, 3'b0, "R10");
      idle(4'b0100, "R10");
      idle(4'b0000, "R10");
      idle(4'b0100, "R10");
      cyc('0, 4'b0100, '0, 0, 0, '0, 0, '0, 0, 0, 1, 3'b000, "R10");

      // Pseudo-random phase over every input
      lfsr = 32'hACE1_1234;
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         for (int k = 0; k < 32; k++)
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         r = lfsr;
         cyc(r[3:0] & r[7:4], r[11:8], r[15:12], r[16], r[17], r[19:18],
             r[20], r[24:21], r[25] & r[26], r[27], (r[31:28] == 4'hF), r[30:28],
             "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule